// File: doc/BRIEF.md
# Maskable Pulsed Interrupt Controller

This block collects event sources from a power-management controller and tells a host about them with a single active-low interrupt line. The line does not stay low. Each qualifying event drives it low for a fixed number of clock cycles (`PULSE_CYC`) and then releases it.

There are two kinds of source:
- **Level sources.** Each one raises an event on the rising edge of its live status bit.
- **Multi-bit state fields.** Examples are a charge-state code or a thermistor-zone code. Each one raises an event whenever its value changes.

Every source has three bits: a live status bit, a sticky flag and a mask bit. A set mask suppresses the pulse for that source, but the flag is still set, so the host can poll for it.

The host uses a plain register port with a 2-bit address and read/write strobes. Reading the flag register returns the flags and clears them in the same cycle.

Status inputs are expected to be synchronous to `clk` already. The default `PULSE_CYC` of 32000 gives 256 µs at 125 MHz.

Top module: `irqc_top`

## Requirements
- R1: After synchronous reset, `irq_n_o` is 1, every flag is 0 and the mask register is 0, so every source is enabled.
- R2: Bit positions are fixed. Level source i uses bit i. State field k uses bit `NUM_LEVEL+k`. A 0-to-1 change of level input i, first sampled at clock edge E, sets flag bit i at E. If that bit is unmasked and no pulse is active, `irq_n_o` is 0 from E onwards.
- R3: A level input that stays at 1, or falls to 0, produces no further event and no pulse.
- R4: Field k occupies `fld_val_i[k*FIELD_W +: FIELD_W]`. Any change of that value is an event on bit `NUM_LEVEL+k`. A field that keeps its value produces no event.
- R5: Each pulse holds `irq_n_o` at 0 for exactly `PULSE_CYC` consecutive cycles.
- R6: When mask bit i is 1, an event on source i sets flag bit i but starts no pulse.
- R7: The register addresses are fixed. Address 1 is the flag register. A read with `reg_re_i` at address 1 puts the flags on `reg_rdata_o` one cycle later and clears every flag.
- R8: A flag read and a new event on the same source in the same cycle leave that flag set. The data returned by that read does not include the new event.
- R9: Events that arrive while a pulse is active, other than in its last cycle, set their flags but neither extend nor restart the pulse.
- R10: An unmasked event in the last cycle of a pulse leaves `irq_n_o` at 1 for exactly one cycle and then starts a new pulse.
- R11: The mask is at address 2 and is written with `reg_we_i` and read back. Address 0 returns the level statuses in bits `[NUM_LEVEL-1:0]` and zeros above. Address 3 returns the concatenated field values. The read data is registered, one cycle after `reg_re_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_stat_i | input | NUM_LEVEL | Live status of the level sources |
| fld_val_i | input | NUM_FIELD*FIELD_W | Concatenated multi-bit state fields |
| reg_addr_i | input | 2 | Register address: 0 status, 1 flags, 2 mask, 3 field values |
| reg_re_i | input | 1 | Register read strobe |
| reg_we_i | input | 1 | Register write strobe, which affects the mask only |
| reg_wdata_i | input | NUM_LEVEL+NUM_FIELD | Write data for the mask |
| reg_rdata_o | output | RD_W | Registered read data |
| irq_n_o | output | 1 | Active-low interrupt pulse |

## Verification
The hardest situation to reach from the ports is an event that falls on the exact last cycle of a running pulse. Missing it by one cycle silently tests the "ignored during pulse" path instead of the hand-over path. The bench starts a pulse from a known edge and counts exactly `PULSE_CYC-1` further clock edges before raising a second source. It then checks for the single high cycle and the new full-length pulse.

The same-cycle read-and-event race is reached by asserting the read strobe and a new status edge in one drive step, then reading the flags again after the pulse.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_FLAG   = 2'd1,
    ADDR_MASK   = 2'd2,
    ADDR_FIELD  = 2'd3
  } irqc_addr_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/irqc_event_detect.sv
module irqc_event_detect #(
  parameter int NUM_LEVEL = 8,
  parameter int NUM_FIELD = 2,
  parameter int FIELD_W   = 3,
  localparam int NSRC     = NUM_LEVEL + NUM_FIELD,
  localparam int FVW      = NUM_FIELD * FIELD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LEVEL-1:0] lvl_i,
  input  logic [FVW-1:0]       fld_i,
  output logic [NSRC-1:0]      evt_o
);
  logic [NUM_LEVEL-1:0] lvl_prev_q;
  logic [FVW-1:0]       fld_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_prev_q <= '0;
      fld_prev_q <= '0;
    end else begin
      lvl_prev_q <= lvl_i;
      fld_prev_q <= fld_i;
    end
  end

  // Level sources: rising edge only
  assign evt_o[NUM_LEVEL-1:0] = lvl_i & ~lvl_prev_q;

  // Field sources: any change of value
  for (genvar k = 0; k < NUM_FIELD; k++) begin : g_field
    assign evt_o[NUM_LEVEL+k] =
      (fld_i[k*FIELD_W +: FIELD_W] != fld_prev_q[k*FIELD_W +: FIELD_W]);
  end
endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int NSRC = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt_i,
  input  logic            clr_i,
  output logic [NSRC-1:0] flag_o
);
  logic [NSRC-1:0] flag_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[i] <= 1'b0;
      end else if (evt_i[i]) begin
        flag_q[i] <= 1'b1;   // a new event wins over a clearing read
      end else if (clr_i) begin
        flag_q[i] <= 1'b0;
      end
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irqc_pulse_timer.sv
module irqc_pulse_timer #(
  parameter int PULSE_CYC = 32000,
  localparam int CNT_W    = (PULSE_CYC > 2) ? $clog2(PULSE_CYC) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic busy_o,
  output logic pend_o
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYC - 1);

  logic             busy_q;
  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= 1'b0;
      if (!busy_q) begin
        if (trig_i || pend_q) begin
          busy_q <= 1'b1;
          cnt_q  <= LOAD;
        end
      end else if (cnt_q == '0) begin
        busy_q <= 1'b0;
        pend_q <= trig_i;   // last-cycle event: one idle cycle, then a new pulse
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_LEVEL = 8,
  parameter int NUM_FIELD = 2,
  parameter int FIELD_W   = 3,
  parameter int PULSE_CYC = 32000,
  localparam int NSRC     = NUM_LEVEL + NUM_FIELD,
  localparam int FVW      = NUM_FIELD * FIELD_W,
  localparam int RD_W     = int'(max_u(NSRC, FVW))
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LEVEL-1:0] lvl_stat_i,
  input  logic [FVW-1:0]       fld_val_i,
  input  logic [1:0]           reg_addr_i,
  input  logic                 reg_re_i,
  input  logic                 reg_we_i,
  input  logic [NSRC-1:0]      reg_wdata_i,
  output logic [RD_W-1:0]      reg_rdata_o,
  output logic                 irq_n_o
);
  logic [NSRC-1:0] evt;
  logic [NSRC-1:0] flag;
  logic [NSRC-1:0] mask_q;
  logic [RD_W-1:0] rdata_q;
  logic [RD_W-1:0] rd_d;
  logic            flag_rd;
  logic            trig;
  logic            busy;
  logic            pend;
  irqc_addr_e      addr;

  assign addr    = irqc_addr_e'(reg_addr_i);
  assign flag_rd = reg_re_i && (addr == ADDR_FLAG);
  assign trig    = |(evt & ~mask_q);

  irqc_event_detect #(
    .NUM_LEVEL (NUM_LEVEL),
    .NUM_FIELD (NUM_FIELD),
    .FIELD_W   (FIELD_W)
  ) u_detect (
    .clk   (clk),
    .rst   (rst),
    .lvl_i (lvl_stat_i),
    .fld_i (fld_val_i),
    .evt_o (evt)
  );

  irqc_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .evt_i  (evt),
    .clr_i  (flag_rd),
    .flag_o (flag)
  );

  irqc_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .trig_i (trig),
    .busy_o (busy),
    .pend_o (pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (reg_we_i && addr == ADDR_MASK) begin
      mask_q <= reg_wdata_i;
    end
  end

  always_comb begin
    rd_d = '0;
    case (addr)
      ADDR_STATUS: rd_d[NUM_LEVEL-1:0] = lvl_stat_i;
      ADDR_FLAG:   rd_d[NSRC-1:0]      = flag;
      ADDR_MASK:   rd_d[NSRC-1:0]      = mask_q;
      ADDR_FIELD:  rd_d[FVW-1:0]       = fld_val_i;
      default:     rd_d                = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_re_i) begin
      rdata_q <= rd_d;
    end
  end

  assign reg_rdata_o = rdata_q;
  assign irq_n_o     = ~busy;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NSRC      = 10,
  parameter int PULSE_CYC = 32000
) (
  input logic            clk,
  input logic            rst,
  input logic            irq_n,
  input logic [NSRC-1:0] evt,
  input logic [NSRC-1:0] mask,
  input logic [NSRC-1:0] flag,
  input logic            pend,
  input logic            flag_rd
);
  logic [31:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || irq_n) low_cnt <= '0;
    else              low_cnt <= low_cnt + 32'd1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (irq_n && flag == '0 && mask == '0)); // R1
  AST_UNMASKED_STARTS: assert property (@(posedge clk) disable iff (rst) (irq_n && |(evt & ~mask)) |=> !irq_n); // R2
  AST_FLAG_CAPTURE: assert property (@(posedge clk) disable iff (rst) (|evt) |=> ((flag & $past(evt)) == $past(evt))); // R8
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst) (irq_n && !pend && !(|(evt & ~mask))) |=> irq_n); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst) (flag_rd && evt == '0) |=> flag == '0); // R7
  AST_WIDTH_EXACT: assert property (@(posedge clk) disable iff (rst) $rose(irq_n) |-> low_cnt == PULSE_CYC); // R5
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst) !irq_n |-> low_cnt < PULSE_CYC); // R9
  AST_HANDOVER_GAP: assert property (@(posedge clk) disable iff (rst) (irq_n && pend) |=> !irq_n); // R10
endmodule

bind irqc_top irqc_chk #(.NSRC(NSRC), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .irq_n   (irq_n_o),
  .evt     (evt),
  .mask    (mask_q),
  .flag    (flag),
  .pend    (pend),
  .flag_rd (flag_rd)
);

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
  localparam int NL   = 8;
  localparam int NF   = 2;
  localparam int FW   = 3;
  localparam int P    = 6;
  localparam int NS   = NL + NF;
  localparam int RDW  = (NS > NF*FW) ? NS : NF*FW;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NL-1:0]   lvl = '0;
  logic [NF*FW-1:0] fld = '0;
  logic [1:0]      addr = '0;
  logic            re = 1'b0;
  logic            we = 1'b0;
  logic [NS-1:0]   wdata = '0;
  logic [RDW-1:0]  rdata;
  logic            irq_n;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  irqc_top #(.NUM_LEVEL(NL), .NUM_FIELD(NF), .FIELD_W(FW), .PULSE_CYC(P)) dut_i (
    .clk(clk), .rst(rst), .lvl_stat_i(lvl), .fld_val_i(fld),
    .reg_addr_i(addr), .reg_re_i(re), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_n_o(irq_n)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    addr = 2'(a); re = 1'b1;
    tick();
    re = 1'b0;
    v = int'(rdata);
  endtask

  task automatic wr_mask(input int v);
    addr = 2'd2; wdata = NS'(v); we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (!irq_n && n < 100) begin
      n++;
      tick();
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v;
    int n;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check("R1 irq_n", int'(irq_n), 1);
    rd(1, v); check("R1 flags", v, 0);
    rd(2, v); check("R1 mask", v, 0);

    // R2/R3/R5/R7 sweep over every level source
    for (int i = 0; i < NL; i++) begin
      lvl[i] = 1'b1;
      tick();
      check("R2 pulse start", int'(irq_n), 0);
      measure(n);
      check("R5 width", n, P);
      repeat (P + 2) begin
        tick();
        check("R3 held high quiet", int'(irq_n), 1);
      end
      rd(1, v); check("R7 flag value", v, 1 << i);
      rd(1, v); check("R7 flag cleared", v, 0);
      lvl[i] = 1'b0;
      tick(); tick();
      check("R3 fall quiet", int'(irq_n), 1);
      rd(1, v); check("R3 no flag on fall", v, 0);
    end

    // R6 masked sources: flag only, no pulse
    wr_mask((1 << NS) - 1);
    rd(2, v); check("R11 mask readback", v, (1 << NS) - 1);
    for (int i = 0; i < NL; i++) begin
      lvl[i] = 1'b1;
      repeat (P + 2) begin
        tick();
        check("R6 masked quiet", int'(irq_n), 1);
      end
      rd(1, v); check("R6 masked flag", v, 1 << i);
      lvl[i] = 1'b0;
      tick();
    end
    wr_mask(0);
    rd(2, v); check("R11 mask zero", v, 0);

    // R4 every field, every value change
    for (int k = 0; k < NF; k++) begin
      for (int val = 1; val < (1 << FW); val++) begin
        fld[k*FW +: FW] = FW'(val);
        tick();
        check("R4 change pulse", int'(irq_n), 0);
        measure(n);
        check("R5 field width", n, P);
        rd(1, v); check("R4 field flag", v, 1 << (NL + k));
        rd(3, v); check("R11 field readback", v, val << (k*FW));
        tick(); tick();
        check("R4 steady quiet", int'(irq_n), 1);
      end
      fld[k*FW +: FW] = '0;
      tick();
      measure(n);
      rd(1, v);
    end

    // R11 status readback
    lvl = 8'hA5;
    tick();
    rd(0, v); check("R11 status", v, 'hA5);
    measure(n);
    rd(1, v);
    lvl = '0;
    tick();

    // R9 event during pulse does not extend
    lvl[0] = 1'b1;
    tick();
    tick();
    lvl[3] = 1'b1;
    measure(n);
    check("R9 not extended", n, P - 1);
    tick();
    check("R9 no restart", int'(irq_n), 1);
    rd(1, v); check("R9 both flags", v, 9);
    lvl = '0;
    tick();

    // R10 event on last pulse cycle
    lvl[0] = 1'b1;
    tick();
    repeat (P - 1) tick();
    check("R10 last cycle low", int'(irq_n), 0);
    lvl[1] = 1'b1;
    tick();
    check("R10 gap high", int'(irq_n), 1);
    tick();
    check("R10 new pulse", int'(irq_n), 0);
    measure(n);
    check("R10 new width", n, P);
    rd(1, v);
    lvl = '0;
    tick();

    // R8 read and new edge in the same cycle
    lvl[2] = 1'b1;
    addr = 2'd1; re = 1'b1;
    tick();
    re = 1'b0;
    check("R8 read excludes new", int'(rdata), 0);
    measure(n);
    rd(1, v); check("R8 flag kept", v, 4);
    lvl = '0;
    tick();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule